// File: doc/BRIEF.md
# SPI Flash Serial Clock and Chip-Select Timing Generator

This block sits beside the shift logic of a serial flash master and owns everything about *when* the wires move. It divides a fast reference clock down to the serial clock and drives the active-low chip-select lines. It also places four programmable guard intervals, counted in reference cycles, around each select edge. A transfer engine asks for a transfer by raising `xfer_start` with a count of serial-clock periods. The block then runs the whole select/clock/deselect sequence and raises `idle` again when a new transfer may begin. Two strobes, aligned with each clock edge, tell the engine whether that edge is a sampling edge or a shifting edge for the programmed clock mode.

Configuration is held in shadow registers that load only while `cfg_enable` is low. Software therefore changes settings by disabling the block, writing, and enabling it again. Disabling the block also aborts any transfer in flight. The select field either names one target, which the block turns into a one-hot-low pattern, or is passed straight through for an external decoder.

Top module: `spi_clk_cs_gen`

## Requirements
- R1: Each serial-clock half period lasts `cfg_baud`+1 reference cycles, so the period is 2*(`cfg_baud`+1). A transfer of N periods produces exactly 2*N clock edges, and N=0 is treated as 1.
- R2: Whenever chip-select is deasserted, and while disabled, `sclk` rests at `cfg_cpol` (0 or 1). It returns to that level after the last edge of a transfer.
- R3: Each clock edge comes with exactly one strobe in the same cycle. With `cfg_cpha`=0, odd-numbered edges (1st, 3rd, ...) raise `sample_tick` and even ones raise `shift_tick`. With `cfg_cpha`=1 the roles swap. No strobe appears without an edge.
- R4: With `cfg_decode`=0, the active `cs_n` is one-hot-low on the index in `cfg_sel` bits [1:0], and bits [3:2] are ignored. Index 0 gives 1110, 1 gives 1101, 2 gives 1011 and 3 gives 0111. The pattern is stable for the whole transfer.
- R5: With `cfg_decode`=1, the active `cs_n` equals the 4-bit `cfg_sel` value unchanged.
- R6: From the cycle `cs_n` asserts to the first `sclk` edge is max(L,1) reference cycles, where L is `cfg_delay`[7:0].
- R7: From the last `sclk` edge to `cs_n` deasserting is max(T,1) cycles, where T is `cfg_delay`[15:8].
- R8: After `cs_n` deasserts, it stays high for max(H,1) cycles before `idle` returns to 1, where H is `cfg_delay`[31:24].
- R9: A transfer is accepted in the cycle `idle` falls. If its select pattern differs from that of the last completed transfer, `cs_n` asserts max(G,1) cycles later, where G is `cfg_delay`[23:16]. Otherwise it asserts in the same cycle. The first transfer after reset has no gap.
- R10: `idle` is 1 only when no transfer is in progress, and then `cs_n` is all ones. After reset `idle`=1, `cs_n`=1111 and `sclk`=0.
- R11: Configuration inputs are ignored while `cfg_enable`=1. While `cfg_enable`=0 a start request is ignored. Dropping `cfg_enable` during a transfer returns the block to idle, with select high and clock at rest, one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Block enable; shadows load while 0 |
| cfg_cpol | input | 1 | Clock rest level |
| cfg_cpha | input | 1 | Clock phase: selects sampling edge |
| cfg_baud | input | 4 | Half-period length minus one |
| cfg_sel | input | 4 | Target index or raw select pattern |
| cfg_decode | input | 1 | 1: pass `cfg_sel` through unchanged |
| cfg_delay | input | 32 | Guard counts: lead, trail, device gap, min high |
| xfer_start | input | 1 | Transfer request, taken when idle |
| xfer_cycles | input | 8 | Serial-clock periods in the transfer |
| sclk | output | 1 | Serial clock |
| cs_n | output | 4 | Active-low chip-selects |
| sample_tick | output | 1 | This cycle's edge is a sampling edge |
| shift_tick | output | 1 | This cycle's edge is a shifting edge |
| idle | output | 1 | No transfer active, select deasserted |

## Verification
The bench sweeps all sixteen divisors. A design that counted the half period off by one, or that toggled once too often or too rarely, would show a wrong edge spacing or edge count. Each guard interval is measured on its own, including the zero setting, which must behave as one cycle rather than vanishing or wrapping to 256. The device gap is checked for the same target, for a changed target, and for the first transfer after reset, so a design that always or never inserts the gap is caught. The bench also changes settings while enabled and aborts a transfer by disabling. A design whose shadows leak, or which keeps clocking after the abort, shows the wrong select pattern or a clock away from its rest level.

// File: rtl/spi_tg_pkg.sv
// Shared types for the serial clock / chip-select timing generator.
// Assumes 8-bit guard counts packed into one 32-bit delay word.
package spi_tg_pkg;

    localparam int DLY_W = 8;

    // Guard counts; lead occupies the low byte, hold_hi the top byte.
    typedef struct packed {
        logic [DLY_W-1:0] hold_hi;  // minimum select-high time
        logic [DLY_W-1:0] dev_gap;  // gap before switching target
        logic [DLY_W-1:0] trail;    // last clock edge to select high
        logic [DLY_W-1:0] lead;     // select low to first clock edge
    } guard_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_LEAD,
        ST_CLOCK,
        ST_TRAIL,
        ST_HOLD
    } tg_state_e;

endpackage

// File: rtl/spi_tg_cfg.sv
// Configuration shadow and chip-select encoder.
// Shadows follow the inputs only while enable is low, so settings are
// frozen while the block runs. Assumes CS_W is a power of two.
module spi_tg_cfg
    import spi_tg_pkg::*;
#(
    parameter int CS_W   = 4,
    parameter int BAUD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cpol_in,
    input  logic              cpha_in,
    input  logic [BAUD_W-1:0] baud_in,
    input  logic [CS_W-1:0]   sel_in,
    input  logic              decode_in,
    input  logic [4*DLY_W-1:0] delay_in,
    output logic              cpol_q,
    output logic              cpha_q,
    output logic [BAUD_W-1:0] baud_q,
    output logic              decode_q,
    output guard_t            guard_q,
    output logic [CS_W-1:0]   cs_code
);

    localparam int SEL_W = (CS_W > 1) ? $clog2(CS_W) : 1;

    logic [CS_W-1:0] sel_q;
    logic [CS_W-1:0] onehot_low;

    // Load shadow registers while the block is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpol_q   <= 1'b0;
            cpha_q   <= 1'b0;
            baud_q   <= '0;
            sel_q    <= '0;
            decode_q <= 1'b0;
            guard_q  <= '0;
        end else if (!cfg_enable) begin
            cpol_q   <= cpol_in;
            cpha_q   <= cpha_in;
            baud_q   <= baud_in;
            sel_q    <= sel_in;
            decode_q <= decode_in;
            guard_q  <= guard_t'(delay_in);
        end
    end

    // One-hot-low pattern: only the indexed line is driven low.
    for (genvar i = 0; i < CS_W; i++) begin : g_onehot
        assign onehot_low[i] = (sel_q[SEL_W-1:0] != SEL_W'(i));
    end

    // Pass raw value through for an external decoder, else use one-hot-low.
    assign cs_code = decode_q ? sel_q : onehot_low;

endmodule

// File: rtl/spi_tg_clkdiv.sv
// Serial-clock divider and edge counter.
// Produces the clock phase (0 = rest level) and per-edge strobes. A kick
// makes the first edge at once; later edges come every baud+1 cycles
// while run is high. Assumes edge_total is even and at least 2.
module spi_tg_clkdiv #(
    parameter int BAUD_W = 4,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kick,
    input  logic              run,
    input  logic [BAUD_W-1:0] baud,
    input  logic              cpha,
    input  logic [CNT_W:0]    edge_total,
    output logic              phase,
    output logic              sample_tick,
    output logic              shift_tick,
    output logic              last_edge
);

    logic [BAUD_W-1:0] half_cnt;
    logic [CNT_W:0]    edge_cnt;
    logic              at_half;
    logic              next_odd;

    assign at_half   = run && (half_cnt == baud);
    assign next_odd  = ~edge_cnt[0];
    assign last_edge = at_half && ((edge_cnt + 1'b1) == edge_total);

    // Count half periods, toggle the phase and flag each edge's role.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase       <= 1'b0;
            half_cnt    <= '0;
            edge_cnt    <= '0;
            sample_tick <= 1'b0;
            shift_tick  <= 1'b0;
        end else if (kick) begin
            phase       <= 1'b1;
            half_cnt    <= '0;
            edge_cnt    <= {{CNT_W{1'b0}}, 1'b1};
            sample_tick <= ~cpha;
            shift_tick  <= cpha;
        end else if (at_half) begin
            phase       <= ~phase;
            half_cnt    <= '0;
            edge_cnt    <= edge_cnt + 1'b1;
            sample_tick <= next_odd ^ cpha;
            shift_tick  <= ~(next_odd ^ cpha);
        end else if (run) begin
            half_cnt    <= half_cnt + 1'b1;
            sample_tick <= 1'b0;
            shift_tick  <= 1'b0;
        end else begin
            phase       <= 1'b0;
            half_cnt    <= '0;
            edge_cnt    <= '0;
            sample_tick <= 1'b0;
            shift_tick  <= 1'b0;
        end
    end

endmodule

// File: rtl/spi_tg_seq.sv
// Transfer sequencer: walks gap, lead, clock, trail and hold phases.
// Each guard phase lasts max(count,1) cycles. Remembers the last completed
// select pattern so the device gap applies only on a target change.
module spi_tg_seq
    import spi_tg_pkg::*;
#(
    parameter int CS_W  = 4,
    parameter int CNT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            start,
    input  logic [CNT_W-1:0] cycles,
    input  logic [CS_W-1:0] code_in,
    input  guard_t          guard,
    input  logic            last_edge,
    output logic            kick,
    output logic            run,
    output logic [CNT_W:0]  edge_total,
    output logic [CS_W-1:0] cs_n,
    output logic            idle
);

    tg_state_e        state;
    logic [DLY_W-1:0] dcnt;
    logic [CS_W-1:0]  cur_code;
    logic [CS_W-1:0]  last_code;
    logic             have_last;
    logic [CNT_W-1:0] cyc_eff;

    assign cyc_eff = (cycles == '0) ? CNT_W'(1) : cycles;
    assign kick    = enable && (state == ST_LEAD) && (dcnt >= guard.lead);
    assign run     = enable && (state == ST_CLOCK);
    assign idle    = (state == ST_IDLE);
    assign cs_n    = (state == ST_LEAD || state == ST_CLOCK || state == ST_TRAIL)
                     ? cur_code : '1;

    // Advance through the transfer phases, counting guard cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            dcnt       <= DLY_W'(1);
            cur_code   <= '1;
            last_code  <= '1;
            have_last  <= 1'b0;
            edge_total <= '0;
        end else if (!enable) begin
            state <= ST_IDLE;
            dcnt  <= DLY_W'(1);
        end else begin
            case (state)
                ST_IDLE: begin
                    dcnt <= DLY_W'(1);
                    if (start) begin
                        cur_code   <= code_in;
                        edge_total <= {cyc_eff, 1'b0};
                        state      <= (have_last && code_in != last_code) ? ST_GAP : ST_LEAD;
                    end
                end
                ST_GAP: begin
                    if (dcnt >= guard.dev_gap) begin
                        state <= ST_LEAD;
                        dcnt  <= DLY_W'(1);
                    end else begin
                        dcnt <= dcnt + 1'b1;
                    end
                end
                ST_LEAD: begin
                    if (kick) state <= ST_CLOCK;
                    else      dcnt  <= dcnt + 1'b1;
                end
                ST_CLOCK: begin
                    if (last_edge) begin
                        state <= ST_TRAIL;
                        dcnt  <= DLY_W'(1);
                    end
                end
                ST_TRAIL: begin
                    if (dcnt >= guard.trail) begin
                        state     <= ST_HOLD;
                        dcnt      <= DLY_W'(1);
                        last_code <= cur_code;
                        have_last <= 1'b1;
                    end else begin
                        dcnt <= dcnt + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (dcnt >= guard.hold_hi) state <= ST_IDLE;
                    else                       dcnt  <= dcnt + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spi_clk_cs_gen.sv
// Top of the serial flash clock and chip-select timing generator.
// Ties the configuration shadow, sequencer and divider together; the
// clock output is the divider phase flipped by the rest level.
module spi_clk_cs_gen #(
    parameter int CS_W   = 4,
    parameter int BAUD_W = 4,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic [BAUD_W-1:0] cfg_baud,
    input  logic [CS_W-1:0]   cfg_sel,
    input  logic              cfg_decode,
    input  logic [31:0]       cfg_delay,
    input  logic              xfer_start,
    input  logic [CNT_W-1:0]  xfer_cycles,
    output logic              sclk,
    output logic [CS_W-1:0]   cs_n,
    output logic              sample_tick,
    output logic              shift_tick,
    output logic              idle
);

    import spi_tg_pkg::*;

    logic              cpol_q;
    logic              cpha_q;
    logic [BAUD_W-1:0] baud_q;
    logic              decode_q;
    guard_t            guard_q;
    logic [CS_W-1:0]   cs_code;
    logic              kick;
    logic              run;
    logic              last_edge;
    logic              phase;
    logic [CNT_W:0]    edge_total;

    spi_tg_cfg #(.CS_W(CS_W), .BAUD_W(BAUD_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_enable(cfg_enable),
        .cpol_in   (cfg_cpol),
        .cpha_in   (cfg_cpha),
        .baud_in   (cfg_baud),
        .sel_in    (cfg_sel),
        .decode_in (cfg_decode),
        .delay_in  (cfg_delay),
        .cpol_q    (cpol_q),
        .cpha_q    (cpha_q),
        .baud_q    (baud_q),
        .decode_q  (decode_q),
        .guard_q   (guard_q),
        .cs_code   (cs_code)
    );

    spi_tg_seq #(.CS_W(CS_W), .CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (cfg_enable),
        .start     (xfer_start),
        .cycles    (xfer_cycles),
        .code_in   (cs_code),
        .guard     (guard_q),
        .last_edge (last_edge),
        .kick      (kick),
        .run       (run),
        .edge_total(edge_total),
        .cs_n      (cs_n),
        .idle      (idle)
    );

    spi_tg_clkdiv #(.BAUD_W(BAUD_W), .CNT_W(CNT_W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .kick       (kick),
        .run        (run),
        .baud       (baud_q),
        .cpha       (cpha_q),
        .edge_total (edge_total),
        .phase      (phase),
        .sample_tick(sample_tick),
        .shift_tick (shift_tick),
        .last_edge  (last_edge)
    );

    // Rest level plus phase gives the serial clock for all four modes.
    assign sclk = phase ^ cpol_q;

endmodule

// File: rtl/spi_tg_chk.sv
// Property checker for the timing generator, bound to the top module.
// Observes ports plus the frozen polarity and decoder shadows.
module spi_tg_chk #(
    parameter int CS_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_enable,
    input logic            sclk,
    input logic [CS_W-1:0] cs_n,
    input logic            idle,
    input logic            sample_tick,
    input logic            shift_tick,
    input logic            cpol_q,
    input logic            decode_q
);

    // R10: idle implies every select line is high.
    a_r10_idle_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (cs_n == {CS_W{1'b1}}));

    // R2: with select released the clock sits at its rest level.
    a_r2_rest_level: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n == {CS_W{1'b1}}) |-> (sclk == cpol_q));

    // R11: one cycle after disable the block is idle.
    a_r11_disable_idles: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> idle);

    // R3: the two strobes never coincide.
    a_r3_ticks_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_tick && shift_tick));

    // R3: a strobe only accompanies a clock edge.
    a_r3_tick_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_tick || shift_tick) |-> (sclk != $past(sclk)));

    // R4: without the decoder exactly one line is low when selected.
    a_r4_onehot_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!decode_q && cs_n != {CS_W{1'b1}}) |-> ($countones(cs_n) == CS_W - 1));

    // R4: the select pattern holds steady through a transfer.
    a_r4_code_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n != {CS_W{1'b1}} && $past(cs_n) != {CS_W{1'b1}}) |-> $stable(cs_n));

endmodule

bind spi_clk_cs_gen spi_tg_chk #(.CS_W(CS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_enable (cfg_enable),
    .sclk       (sclk),
    .cs_n       (cs_n),
    .idle       (idle),
    .sample_tick(sample_tick),
    .shift_tick (shift_tick),
    .cpol_q     (cpol_q),
    .decode_q   (decode_q)
);

// File: tb/spi_clk_cs_gen_bench.sv
// Directed bench: each task drives one scenario and checks its own timing.
module spi_clk_cs_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b0;
    logic        cfg_cpol = 1'b0;
    logic        cfg_cpha = 1'b0;
    logic [3:0]  cfg_baud = '0;
    logic [3:0]  cfg_sel = '0;
    logic        cfg_decode = 1'b0;
    logic [31:0] cfg_delay = '0;
    logic        xfer_start = 1'b0;
    logic [7:0]  xfer_cycles = '0;
    logic        sclk;
    logic [3:0]  cs_n;
    logic        sample_tick;
    logic        shift_tick;
    logic        idle;

    spi_clk_cs_gen u_spi_clk_cs_gen (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_cpol(cfg_cpol),
        .cfg_cpha(cfg_cpha), .cfg_baud(cfg_baud), .cfg_sel(cfg_sel),
        .cfg_decode(cfg_decode), .cfg_delay(cfg_delay), .xfer_start(xfer_start),
        .xfer_cycles(xfer_cycles), .sclk(sclk), .cs_n(cs_n),
        .sample_tick(sample_tick), .shift_tick(shift_tick), .idle(idle)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Bench copy of the settings in force
    bit       b_cpol, b_cpha, b_decode;
    int       b_baud;
    bit [3:0] b_sel;
    int       b_l, b_t, b_g, b_h;
    bit       have_last = 1'b0;
    bit [3:0] last_code = 4'hF;

    // Measurements from the last transfer
    int t_idle_fall, t_cs_fall, t_first, t_last, t_cs_rise, t_idle_rise;
    int n_edges, hp_min, hp_max, tick_err;
    bit [3:0] cs_seen;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int atl1(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic bit [3:0] exp_code();
        return b_decode ? b_sel : ~(4'b0001 << b_sel[1:0]);
    endfunction

    task automatic configure(input bit cpol, input bit cpha, input int baud,
                             input bit [3:0] sel, input bit dec,
                             input int l, input int t, input int g, input int h);
        @(negedge clk);
        cfg_enable = 1'b0;
        cfg_cpol = cpol; cfg_cpha = cpha; cfg_baud = baud[3:0];
        cfg_sel = sel; cfg_decode = dec;
        cfg_delay = {h[7:0], g[7:0], t[7:0], l[7:0]};
        b_cpol = cpol; b_cpha = cpha; b_baud = baud; b_sel = sel; b_decode = dec;
        b_l = l; b_t = t; b_g = g; b_h = h;
        @(negedge clk);
        @(negedge clk);
        cfg_enable = 1'b1;
        @(negedge clk);
    endtask

    // Start one transfer and timestamp every port event until idle returns.
    task automatic run_xfer(input int ncyc);
        bit p_sclk, p_idle;
        bit [3:0] p_cs;
        bit exp_s;
        @(negedge clk);
        xfer_cycles = ncyc[7:0];
        xfer_start = 1'b1;
        p_sclk = sclk; p_cs = cs_n; p_idle = idle;
        n_edges = 0; hp_min = 1000000; hp_max = 0; tick_err = 0;
        t_idle_fall = -1; t_cs_fall = -1; t_first = -1; t_last = -1;
        t_cs_rise = -1; t_idle_rise = -1; cs_seen = 4'hF;
        for (int k = 0; k < 6000; k++) begin
            @(negedge clk);
            if (p_idle && !idle) begin
                t_idle_fall = cyc;
                xfer_start = 1'b0;
            end
            if (p_cs == 4'hF && cs_n != 4'hF) begin
                t_cs_fall = cyc;
                cs_seen = cs_n;
            end
            if (p_cs != 4'hF && cs_n == 4'hF) t_cs_rise = cyc;
            if (sclk != p_sclk) begin
                n_edges++;
                if (n_edges == 1) t_first = cyc;
                else begin
                    if (cyc - t_last < hp_min) hp_min = cyc - t_last;
                    if (cyc - t_last > hp_max) hp_max = cyc - t_last;
                end
                t_last = cyc;
                exp_s = ((n_edges % 2) == 1) ^ b_cpha;
                if (sample_tick !== exp_s || shift_tick !== !exp_s) tick_err++;
            end else if (sample_tick || shift_tick) begin
                tick_err++;
            end
            if (!p_idle && idle) begin
                t_idle_rise = cyc;
                break;
            end
            p_sclk = sclk; p_cs = cs_n; p_idle = idle;
        end
        xfer_start = 1'b0;
    endtask

    // Run a transfer and check every timing relation against the settings.
    task automatic xfer_and_check(input int ncyc);
        bit [3:0] ec;
        int exp_gap;
        ec = exp_code();
        exp_gap = (have_last && ec != last_code) ? atl1(b_g) : 0;
        run_xfer(ncyc);
        chk(cs_seen == ec, "R4/R5", "select pattern", cs_seen, ec);
        chk(n_edges == 2 * atl1(ncyc), "R1", "edge count", n_edges, 2 * atl1(ncyc));
        chk(hp_min == b_baud + 1 && hp_max == b_baud + 1, "R1", "half period",
            hp_max, b_baud + 1);
        chk(t_cs_fall - t_idle_fall == exp_gap, "R9", "device gap",
            t_cs_fall - t_idle_fall, exp_gap);
        chk(t_first - t_cs_fall == atl1(b_l), "R6", "lead", t_first - t_cs_fall, atl1(b_l));
        chk(t_cs_rise - t_last == atl1(b_t), "R7", "trail", t_cs_rise - t_last, atl1(b_t));
        chk(t_idle_rise - t_cs_rise == atl1(b_h), "R8", "min high",
            t_idle_rise - t_cs_rise, atl1(b_h));
        chk(tick_err == 0, "R3", "strobe errors", tick_err, 0);
        chk(sclk == b_cpol, "R2", "rest level after", sclk, b_cpol);
        have_last = 1'b1;
        last_code = ec;
    endtask

    task automatic t_reset();
        chk(idle == 1'b1, "R10", "reset idle", idle, 1);
        chk(cs_n == 4'hF, "R10", "reset cs_n", cs_n, 15);
        chk(sclk == 1'b0, "R10", "reset sclk", sclk, 0);
    endtask

    task automatic t_basic();
        configure(0, 0, 1, 4'd0, 0, 2, 3, 4, 5);
        xfer_and_check(3);   // first transfer: R9 no gap
        xfer_and_check(3);   // same target: R9 no gap
    endtask

    task automatic t_switch_target();
        configure(0, 0, 1, 4'd2, 0, 2, 3, 4, 5);
        xfer_and_check(2);   // R4 1011, R9 gap
        configure(0, 0, 2, 4'b1101, 0, 1, 1, 6, 2);
        xfer_and_check(1);   // R4 upper bits ignored: index 1 -> 1101
    endtask

    task automatic t_decoder();
        configure(0, 1, 0, 4'b0101, 1, 3, 2, 7, 3);
        xfer_and_check(2);   // R5 raw pattern 0101
    endtask

    task automatic t_modes();
        for (int m = 0; m < 4; m++) begin
            configure(m[1], m[0], 2, 4'b0101, 1, 1, 1, 1, 1);
            chk(sclk == m[1], "R2", "rest level before", sclk, m[1]);
            xfer_and_check(2);
        end
    endtask

    task automatic t_div_sweep();
        for (int b = 0; b < 16; b++) begin
            configure(0, 0, b, 4'd3, 0, 1, 1, 1, 1);
            xfer_and_check(2);
        end
    endtask

    task automatic t_zero_delays();
        configure(0, 0, 0, 4'd1, 0, 0, 0, 0, 0);
        xfer_and_check(0);   // R1 zero periods -> one; R6/R7/R8/R9 zero -> one
    endtask

    task automatic t_random_delays();
        for (int i = 0; i < 8; i++) begin
            configure($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 15),
                      4'($urandom_range(0, 3)), 0,
                      $urandom_range(0, 40), $urandom_range(0, 40),
                      $urandom_range(0, 40), $urandom_range(0, 40));
            xfer_and_check($urandom_range(1, 4));
        end
    endtask

    task automatic t_cfg_locked();
        configure(0, 0, 1, 4'd0, 0, 2, 2, 2, 2);
        @(negedge clk);
        cfg_baud = 4'd7; cfg_sel = 4'd3; cfg_delay = 32'h0909_0909; cfg_cpol = 1'b1;
        xfer_and_check(2);   // R11: old pattern, period and guards still apply
        cfg_baud = 4'(b_baud); cfg_sel = b_sel; cfg_cpol = b_cpol;
        cfg_delay = {b_h[7:0], b_g[7:0], b_t[7:0], b_l[7:0]};
    endtask

    task automatic t_disable_abort();
        bit p_sclk;
        int stray;
        configure(1, 0, 3, 4'd2, 0, 2, 2, 2, 2);
        @(negedge clk);
        xfer_cycles = 8'd50; xfer_start = 1'b1;
        @(negedge clk);
        xfer_start = 1'b0;
        repeat (15) @(negedge clk);
        chk(cs_n == 4'b1011, "R11", "mid transfer select", cs_n, 11);
        cfg_enable = 1'b0;
        @(negedge clk);
        chk(idle == 1'b1, "R11", "abort idle", idle, 1);
        chk(cs_n == 4'hF, "R11", "abort cs_n", cs_n, 15);
        chk(sclk == 1'b1, "R11", "abort sclk rest", sclk, 1);
        xfer_start = 1'b1;
        stray = 0;
        p_sclk = sclk;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (!idle || cs_n != 4'hF || sclk != p_sclk) stray++;
        end
        xfer_start = 1'b0;
        chk(stray == 0, "R11", "start ignored while disabled", stray, 0);
        @(negedge clk);
        cfg_enable = 1'b1;
        @(negedge clk);
        // aborted transfer did not complete, so last pattern is unchanged
        xfer_and_check(1);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_switch_target();
        t_decoder();
        t_modes();
        t_div_sweep();
        t_zero_delays();
        t_random_delays();
        t_cfg_locked();
        t_disable_abort();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule